// File: doc/BRIEF.md
# Floating-Point Conditional Debug Trap

This block decides whether a conditional "enter debug" instruction stops the processor. It is given a 5-bit condition selector, the floating-point status flags (negative, zero, infinity, not-a-number) and the external error-register bits. When the selected predicate holds, the block parks the instruction stream in a halted state. It leaves that state only when the debug port sends a resume pulse. When the predicate fails, it issues a one-cycle continue pulse so that the sequencer moves on to the next instruction.

Twelve of the predicates are "non-aware" ordered comparisons. Evaluating one of them while the not-a-number flag is set has a side effect: it raises a sticky unordered-condition bit and a sticky invalid-operation interrupt flag. Each of these bits stays set until its own synchronous clear input is pulsed. The block never writes the main condition code flags; they are inputs only.

Top module: `fdt_trap_unit`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it rises, `halted_o`, `continue_o`, `uncc_o` and `iop_o` are all 0.
- R2: The flag-only predicates, by selector code: 0 EQ (Z), 10 NE (!Z), 6 INF (I), 15 NINF (!I), 9 MI (N), 19 PL (!N), 18 OR (!NAN), 20 UN (NAN). None of them changes `uncc_o` or `iop_o`.
- R3: The ordered comparisons, by selector code: 5 GT is true when (NAN|Z|N)=0; 2 GE when (NAN|(N&!Z))=0; 8 LT when (NAN|Z|!N)=0; 7 LE when (NAN|!(N|Z))=0; 3 GL when (NAN|Z)=0; 4 GLE when NAN=0.
- R4: The negated comparisons are the logical complements of their R3 partners: 14 NGT, 11 NGE, 17 NLT, 16 NLE, 12 NGL, 13 NGLE.
- R5: Code 1 (ERR) is true when any bit of `err_ext_i` is 1, or when `uncc_o` is already 1. The bits of `err_ext_i` are [4] SNAN, [3] OPERR, [2] OVF, [1] UNF, [0] DZ.
- R6: A true evaluation sets `halted_o` on the clock edge that samples `eval_i`. `halted_o` then stays 1 until `resume_i` is sampled high, and it falls on that edge.
- R7: A false evaluation drives `continue_o` high for exactly the one cycle after the strobe. `halted_o` stays 0.
- R8: An accepted evaluation of any R3 or R4 code with NAN=1 sets both `uncc_o` and `iop_o`, and they stay set.
- R9: `clr_uncc_i` clears `uncc_o` and `clr_iop_i` clears `iop_o` on the next edge. A set in the same cycle wins over a clear.
- R10: Codes 21 to 31 evaluate false, which gives a continue pulse, and they never set `uncc_o` or `iop_o`.
- R11: While halted, `eval_i` is ignored: there is no continue pulse and no flag change, and the block stays halted. While running, `resume_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_i | input | 1 | One-cycle evaluate strobe |
| cond_sel_i | input | 5 | Condition selector code |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_inf_i | input | 1 | Infinity flag |
| flag_nan_i | input | 1 | Not-a-number flag |
| err_ext_i | input | 5 | External error bits {SNAN,OPERR,OVF,UNF,DZ} |
| resume_i | input | 1 | Debug-port resume pulse |
| clr_uncc_i | input | 1 | Clear for the unordered-condition bit |
| clr_iop_i | input | 1 | Clear for the invalid-operation flag |
| halted_o | output | 1 | High while in debug state |
| continue_o | output | 1 | One-cycle pulse after a false evaluation |
| uncc_o | output | 1 | Sticky unordered-condition bit |
| iop_o | output | 1 | Sticky invalid-operation interrupt flag |

## Verification
The bench sweeps every selector code against all sixteen flag combinations and checks the result and the flag side effects. A swapped or mis-inverted predicate shows up as a halt where a continue was expected, and a misclassified aware code shows up as a spurious or missing sticky bit. Directed scenarios cover the following corner cases:
- ERR fed from each external bit and from the block's own sticky bit; a design that ignores the feedback misses a halt.
- A set arriving in the same cycle as a clear; a clear-priority design drops the flag.
- A strobe arriving while halted; a design that does not gate it emits a continue pulse or raises flags.
- A stray resume while running; a design that does not ignore it breaks the next halt.

// File: rtl/fdt_pkg.sv
// Package: shared constants and types for the floating-point debug trap.
// Assumes selector codes are dense from 0; codes above CC_UN are unused.
package fdt_pkg;
    localparam int SEL_W    = 5;
    localparam int ERR_W    = 5;
    localparam int FLAG_CNT = 2;
    localparam int FLAG_UNCC = 0;
    localparam int FLAG_IOP  = 1;

    typedef enum logic [SEL_W-1:0] {
        CC_EQ   = 5'd0,  CC_ERR = 5'd1,  CC_GE  = 5'd2,  CC_GL   = 5'd3,
        CC_GLE  = 5'd4,  CC_GT  = 5'd5,  CC_INF = 5'd6,  CC_LE   = 5'd7,
        CC_LT   = 5'd8,  CC_MI  = 5'd9,  CC_NE  = 5'd10, CC_NGE  = 5'd11,
        CC_NGL  = 5'd12, CC_NGLE = 5'd13, CC_NGT = 5'd14, CC_NINF = 5'd15,
        CC_NLE  = 5'd16, CC_NLT = 5'd17, CC_OR  = 5'd18, CC_PL   = 5'd19,
        CC_UN   = 5'd20
    } fdt_cond_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } fdt_state_e;
endpackage

// File: rtl/fdt_cond_eval.sv
// Module: fdt_cond_eval
// Combinational predicate evaluator. Returns whether the selected condition
// holds and whether the selected code belongs to the non-aware family.
// Assumes: flags are stable during the evaluate cycle; unused codes are false.
module fdt_cond_eval
    import fdt_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int EW = ERR_W
) (
    input  logic [SW-1:0] sel_i,
    input  logic          n_i,
    input  logic          z_i,
    input  logic          inf_i,
    input  logic          nan_i,
    input  logic [EW-1:0] err_i,
    input  logic          uncc_i,
    output logic          true_o,
    output logic          non_aware_o
);
    logic gt_f, ge_f, lt_f, le_f, gl_f, gle_f;

    // Purpose: raw "false" terms of the ordered comparisons.
    always_comb begin
        gt_f  = nan_i | z_i | n_i;
        ge_f  = nan_i | (n_i & ~z_i);
        lt_f  = nan_i | z_i | ~n_i;
        le_f  = nan_i | ~(n_i | z_i);
        gl_f  = nan_i | z_i;
        gle_f = nan_i;
    end

    // Purpose: select predicate value and its awareness class.
    always_comb begin
        true_o      = 1'b0;
        non_aware_o = 1'b0;
        case (sel_i)
            CC_EQ:   true_o = z_i;
            CC_NE:   true_o = ~z_i;
            CC_ERR:  true_o = (|err_i) | uncc_i;
            CC_INF:  true_o = inf_i;
            CC_NINF: true_o = ~inf_i;
            CC_MI:   true_o = n_i;
            CC_PL:   true_o = ~n_i;
            CC_OR:   true_o = ~nan_i;
            CC_UN:   true_o = nan_i;
            CC_GT:   begin true_o = ~gt_f;  non_aware_o = 1'b1; end
            CC_GE:   begin true_o = ~ge_f;  non_aware_o = 1'b1; end
            CC_LT:   begin true_o = ~lt_f;  non_aware_o = 1'b1; end
            CC_LE:   begin true_o = ~le_f;  non_aware_o = 1'b1; end
            CC_GL:   begin true_o = ~gl_f;  non_aware_o = 1'b1; end
            CC_GLE:  begin true_o = ~gle_f; non_aware_o = 1'b1; end
            CC_NGT:  begin true_o = gt_f;   non_aware_o = 1'b1; end
            CC_NGE:  begin true_o = ge_f;   non_aware_o = 1'b1; end
            CC_NLT:  begin true_o = lt_f;   non_aware_o = 1'b1; end
            CC_NLE:  begin true_o = le_f;   non_aware_o = 1'b1; end
            CC_NGL:  begin true_o = gl_f;   non_aware_o = 1'b1; end
            CC_NGLE: begin true_o = gle_f;  non_aware_o = 1'b1; end
            default: begin true_o = 1'b0;   non_aware_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fdt_sticky_flags.sv
// Module: fdt_sticky_flags
// Bank of sticky bits, each with its own set and synchronous clear.
// Assumes: set has priority over clear when both arrive together.
module fdt_sticky_flags #(
    parameter int CNT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CNT-1:0] set_i,
    input  logic [CNT-1:0] clr_i,
    output logic [CNT-1:0] q_o
);
    for (genvar g = 0; g < CNT; g++) begin : g_bit
        // Purpose: hold one sticky bit; set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         q_o[g] <= 1'b0;
            else if (set_i[g])  q_o[g] <= 1'b1;
            else if (clr_i[g])  q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/fdt_trap_ctrl.sv
// Module: fdt_trap_ctrl
// Run/halt sequencer. Accepts a strobe only while running, halts on a true
// result, pulses continue on a false one, and leaves halt on resume.
// Assumes: resume while running is meaningless and is dropped.
module fdt_trap_ctrl
    import fdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval_i,
    input  logic cond_true_i,
    input  logic resume_i,
    output logic accept_o,
    output logic halted_o,
    output logic continue_o
);
    fdt_state_e state_q;

    // Purpose: a strobe counts only while running.
    always_comb accept_o = eval_i & (state_q == ST_RUN);

    // Purpose: state transitions between run and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            case (state_q)
                ST_RUN:  if (accept_o && cond_true_i) state_q <= ST_HALT;
                ST_HALT: if (resume_i)                state_q <= ST_RUN;
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Purpose: one-cycle continue pulse after a false evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) continue_o <= 1'b0;
        else        continue_o <= accept_o & ~cond_true_i;
    end

    always_comb halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/fdt_trap_unit.sv
// Module: fdt_trap_unit (top)
// Conditional debug trap: evaluates a floating-point predicate on a strobe,
// halts or continues, and records non-aware unordered tests in sticky bits.
// Assumes: flags are valid in the cycle eval_i is high.
module fdt_trap_unit
    import fdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_i,
    input  logic [SEL_W-1:0] cond_sel_i,
    input  logic             flag_n_i,
    input  logic             flag_z_i,
    input  logic             flag_inf_i,
    input  logic             flag_nan_i,
    input  logic [ERR_W-1:0] err_ext_i,
    input  logic             resume_i,
    input  logic             clr_uncc_i,
    input  logic             clr_iop_i,
    output logic             halted_o,
    output logic             continue_o,
    output logic             uncc_o,
    output logic             iop_o
);
    logic                cond_true;
    logic                non_aware;
    logic                accept;
    logic [FLAG_CNT-1:0] flag_set;
    logic [FLAG_CNT-1:0] flag_clr;
    logic [FLAG_CNT-1:0] flag_q;

    fdt_cond_eval #(.SW(SEL_W), .EW(ERR_W)) u_eval (
        .sel_i       (cond_sel_i),
        .n_i         (flag_n_i),
        .z_i         (flag_z_i),
        .inf_i       (flag_inf_i),
        .nan_i       (flag_nan_i),
        .err_i       (err_ext_i),
        .uncc_i      (flag_q[FLAG_UNCC]),
        .true_o      (cond_true),
        .non_aware_o (non_aware)
    );

    fdt_trap_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval_i      (eval_i),
        .cond_true_i (cond_true),
        .resume_i    (resume_i),
        .accept_o    (accept),
        .halted_o    (halted_o),
        .continue_o  (continue_o)
    );

    // Purpose: unordered test of a non-aware predicate raises both flags.
    always_comb begin
        flag_set           = {FLAG_CNT{accept & non_aware & flag_nan_i}};
        flag_clr           = '0;
        flag_clr[FLAG_UNCC] = clr_uncc_i;
        flag_clr[FLAG_IOP]  = clr_iop_i;
    end

    fdt_sticky_flags #(.CNT(FLAG_CNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flag_q)
    );

    assign uncc_o = flag_q[FLAG_UNCC];
    assign iop_o  = flag_q[FLAG_IOP];
endmodule

// File: rtl/fdt_trap_checker.sv
// Module: fdt_trap_checker
// Temporal properties over the trap unit's ports; bound to every instance.
module fdt_trap_checker (
    input logic clk,
    input logic rst_n,
    input logic eval_i,
    input logic resume_i,
    input logic clr_uncc_i,
    input logic clr_iop_i,
    input logic halted_o,
    input logic continue_o,
    input logic uncc_o,
    input logic iop_o
);
    a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && !resume_i |=> halted_o);

    a_r6_resume_releases: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && resume_i |=> !halted_o);

    a_r7_continue_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(continue_o) |-> $past(eval_i) && !$past(halted_o));

    a_r7_no_continue_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted_o && continue_o));

    a_r8_uncc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        uncc_o && !clr_uncc_i |=> uncc_o);

    a_r8_iop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        iop_o && !clr_iop_i |=> iop_o);

    a_r11_halt_ignores_eval: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && eval_i && !resume_i |=> halted_o && !continue_o);

    a_r11_halt_no_new_uncc: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && !uncc_o |=> !$rose(uncc_o));
endmodule

bind fdt_trap_unit fdt_trap_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval_i),
    .resume_i   (resume_i),
    .clr_uncc_i (clr_uncc_i),
    .clr_iop_i  (clr_iop_i),
    .halted_o   (halted_o),
    .continue_o (continue_o),
    .uncc_o     (uncc_o),
    .iop_o      (iop_o)
);

// File: tb/tb_fdt_trap_unit.sv
module tb_fdt_trap_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eval_i = 1'b0;
    logic [4:0] cond_sel_i = '0;
    logic       flag_n_i = 1'b0, flag_z_i = 1'b0, flag_inf_i = 1'b0, flag_nan_i = 1'b0;
    logic [4:0] err_ext_i = '0;
    logic       resume_i = 1'b0, clr_uncc_i = 1'b0, clr_iop_i = 1'b0;
    logic       halted_o, continue_o, uncc_o, iop_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdt_trap_unit dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cond_sel_i(cond_sel_i),
        .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_inf_i(flag_inf_i),
        .flag_nan_i(flag_nan_i), .err_ext_i(err_ext_i), .resume_i(resume_i),
        .clr_uncc_i(clr_uncc_i), .clr_iop_i(clr_iop_i), .halted_o(halted_o),
        .continue_o(continue_o), .uncc_o(uncc_o), .iop_o(iop_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Reference predicate written from the requirement formulas.
    function automatic logic ref_true(input int s, input logic n, input logic z,
                                      input logic i, input logic nan,
                                      input logic [4:0] e, input logic u);
        case (s)
            0:  return z;
            1:  return (|e) | u;
            2:  return !(nan | (n & !z));
            3:  return !(nan | z);
            4:  return !nan;
            5:  return !(nan | z | n);
            6:  return i;
            7:  return !(nan | !(n | z));
            8:  return !(nan | z | !n);
            9:  return n;
            10: return !z;
            11: return nan | (n & !z);
            12: return nan | z;
            13: return nan;
            14: return nan | z | n;
            15: return !i;
            16: return nan | !(n | z);
            17: return nan | z | !n;
            18: return !nan;
            19: return !n;
            20: return nan;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ref_non_aware(input int s);
        return (s inside {2, 3, 4, 5, 7, 8, 11, 12, 13, 14, 16, 17});
    endfunction

    function automatic string tag_of(input int s);
        if (s == 1) return "R5";
        if (s inside {2, 3, 4, 5, 7, 8}) return "R3";
        if (s inside {11, 12, 13, 14, 16, 17}) return "R4";
        if (s > 20) return "R10";
        return "R2";
    endfunction

    task automatic clear_flags();
        @(negedge clk); clr_uncc_i = 1'b1; clr_iop_i = 1'b1;
        @(negedge clk); clr_uncc_i = 1'b0; clr_iop_i = 1'b0;
    endtask

    task automatic do_resume(input string req);
        resume_i = 1'b1;
        @(negedge clk); resume_i = 1'b0;
        check(req, "halted after resume", halted_o, 1'b0);
    endtask

    // One strobe; on return, we are at the negedge after the sampling edge.
    task automatic strobe(input int s, input logic n, input logic z, input logic i, input logic nan);
        @(negedge clk);
        cond_sel_i = 5'(s); flag_n_i = n; flag_z_i = z; flag_inf_i = i; flag_nan_i = nan;
        eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "halted in reset", halted_o, 1'b0);
        check("R1", "continue in reset", continue_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "halted after reset", halted_o, 1'b0);
        check("R1", "continue after reset", continue_o, 1'b0);
        check("R1", "uncc after reset", uncc_o, 1'b0);
        check("R1", "iop after reset", iop_o, 1'b0);
    endtask

    // R2 R3 R4 R10: every code against every flag combination.
    task automatic t_sweep();
        for (int s = 0; s < 32; s++) begin
            for (int v = 0; v < 16; v++) begin
                logic n, z, i, nan, exp;
                string tg;
                n = v[0]; z = v[1]; i = v[2]; nan = v[3];
                exp = ref_true(s, n, z, i, nan, 5'd0, 1'b0);
                tg = tag_of(s);
                strobe(s, n, z, i, nan);
                check(tg, $sformatf("halt sel=%0d v=%0d", s, v), halted_o, exp);
                check(exp ? "R6" : "R7", $sformatf("continue sel=%0d v=%0d", s, v), continue_o, !exp);
                check(ref_non_aware(s) ? "R8" : tg, $sformatf("uncc sel=%0d v=%0d", s, v),
                      uncc_o, ref_non_aware(s) && nan);
                check(ref_non_aware(s) ? "R8" : tg, $sformatf("iop sel=%0d v=%0d", s, v),
                      iop_o, ref_non_aware(s) && nan);
                if (halted_o) do_resume("R6");
                if (uncc_o || iop_o) clear_flags();
            end
        end
    endtask

    // R5: ERR from each external bit and from the sticky unordered bit.
    task automatic t_err();
        for (int b = 0; b < 5; b++) begin
            err_ext_i = 5'(1 << b);
            strobe(1, 1'b0, 1'b0, 1'b0, 1'b0);
            check("R5", $sformatf("ERR ext bit %0d", b), halted_o, 1'b1);
            do_resume("R6");
        end
        err_ext_i = '0;
        strobe(1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "ERR all clear", continue_o, 1'b1);
        strobe(5, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8", "uncc set by GT unordered", uncc_o, 1'b1);
        strobe(1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "ERR via sticky uncc", halted_o, 1'b1);
        do_resume("R6");
        clear_flags();
    endtask

    // R6 R7: halt persistence and continue pulse width.
    task automatic t_halt_and_continue();
        strobe(0, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check("R6", "halt persists without resume", halted_o, 1'b1);
        do_resume("R6");
        strobe(0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7", "continue pulse", continue_o, 1'b1);
        @(negedge clk);
        check("R7", "continue one cycle only", continue_o, 1'b0);
        check("R7", "no halt on false", halted_o, 1'b0);
    endtask

    // R8 R9: stickiness, separate clears, set beats clear.
    task automatic t_sticky();
        strobe(14, 1'b0, 1'b0, 1'b0, 1'b1);
        if (halted_o) do_resume("R6");
        repeat (3) @(negedge clk);
        check("R8", "uncc holds", uncc_o, 1'b1);
        check("R8", "iop holds", iop_o, 1'b1);
        @(negedge clk); clr_uncc_i = 1'b1;
        @(negedge clk); clr_uncc_i = 1'b0;
        check("R9", "uncc cleared", uncc_o, 1'b0);
        check("R9", "iop kept by uncc clear", iop_o, 1'b1);
        @(negedge clk); clr_iop_i = 1'b1;
        @(negedge clk); clr_iop_i = 1'b0;
        check("R9", "iop cleared", iop_o, 1'b0);
        @(negedge clk);
        cond_sel_i = 5'd5; flag_nan_i = 1'b1; eval_i = 1'b1;
        clr_uncc_i = 1'b1; clr_iop_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0; clr_uncc_i = 1'b0; clr_iop_i = 1'b0; flag_nan_i = 1'b0;
        check("R9", "uncc set wins over clear", uncc_o, 1'b1);
        check("R9", "iop set wins over clear", iop_o, 1'b1);
        clear_flags();
    endtask

    // R11: strobes during halt and resume during run are dropped.
    task automatic t_ignore();
        strobe(0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6", "halt entered", halted_o, 1'b1);
        strobe(5, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11", "still halted", halted_o, 1'b1);
        check("R11", "no continue while halted", continue_o, 1'b0);
        check("R11", "no uncc while halted", uncc_o, 1'b0);
        check("R11", "no iop while halted", iop_o, 1'b0);
        do_resume("R6");
        @(negedge clk); resume_i = 1'b1;
        @(negedge clk); resume_i = 1'b0;
        check("R11", "resume while running", halted_o, 1'b0);
        strobe(0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R11", "halt after stray resume", halted_o, 1'b1);
        do_resume("R6");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_halt_and_continue();
        t_sweep();
        t_err();
        t_sticky();
        t_ignore();
        summary();
    end
endmodule